// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block scans a 24-bit parallel-RGB TFT panel. It runs in the pixel clock domain and produces an active-low horizontal sync, an active-low vertical sync and a data-enable. It also drives the pixel coordinates to an upstream pixel source, takes that source's colour back and registers it onto the panel bus. The syncs, data-enable and colour are registered together, so all panel pins leave the block in the same cycle.

Four geometry profiles exist. Three are fixed panel geometries: 800x480, 480x272 and 400x240. The fourth is built from parameters. The profile comes from the `prof_sel` input, or from a parameter when `USE_SEL_PIN` is 0. A new selection takes effect only when a frame wraps. In each line the sync pulse opens the back porch. The back porch is counted from the sync falling edge, and it is followed by the active region and then the front porch. The vertical axis has the same structure, counted in lines.

The pixel interface is a request stream that cannot be stalled. `pix_req` is the ready side, and the block takes one pixel in every cycle it is high. The source has no valid and cannot apply back-pressure. It must present `pix_rgb` for the `pix_x`/`pix_y` shown in that same cycle, for example from a lookup. `pix_x`/`pix_y` lead the panel bus by one clock.

Top module: `lcdt_panel_timing`

## Requirements
- R1: While reset is low and right after it, `lcd_hsync_n` and `lcd_vsync_n` are 1, and `lcd_de`, `pix_req`, `frame_start` and `lcd_rgb` are 0.
- R2: The line length in clocks is 1056 for profile code 0, 525 for code 1, 528 for code 2 and CUST_HACT+CUST_HBP+CUST_HFP for code 3. `lcd_hsync_n` is low for the first HSW clocks of every line.
- R3: `lcd_de` rises exactly HBP clocks after `lcd_hsync_n` falls and stays high for the active width. HBP is 216, 43, 108 or CUST_HBP, and the active width is 800, 480, 400 or CUST_HACT, for codes 0 to 3. It is high only on active lines.
- R4: The frame length in lines is 525 (480 active, 35 back, 10 front) for code 0, 286 (272/12/2) for code 1, 262 (240/20/2) for code 2 and the custom sum for code 3. `lcd_vsync_n` is low for the first VSW lines and falls together with `lcd_hsync_n`. Active lines start VBP lines after the fall.
- R5: `pix_req` is high exactly one clock before each `lcd_de` high clock. During it, `pix_x` counts 0 up to the active width minus 1 along the line and `pix_y` gives the active line index.
- R6: `lcd_rgb` equals the `pix_rgb` value present during the matching `pix_req` clock. It is 0 whenever `lcd_de` is low.
- R7: `frame_start` is high for one clock per frame, on the first active pixel (x=0, y=0), together with `lcd_de`.
- R8: `prof_sel` is sampled only during reset and at the clock where the last pixel of a frame wraps. A change in mid-frame leaves the line and frame timing unchanged until the next frame begins.
- R9: With `USE_SEL_PIN`=0 the profile is the `PROFILE` parameter, and `prof_sel` has no effect on the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prof_sel | input | 2 | Geometry profile code (0..3) |
| pix_req | output | 1 | Pixel request (ready) to the source |
| pix_x | output | 11 | Active column of the requested pixel |
| pix_y | output | 10 | Active line of the requested pixel |
| pix_rgb | input | 24 | Colour for the requested pixel, same cycle |
| lcd_hsync_n | output | 1 | Horizontal sync, active low |
| lcd_vsync_n | output | 1 | Vertical sync, active low |
| lcd_de | output | 1 | Data enable |
| lcd_rgb | output | 24 | Registered colour to the panel |
| frame_start | output | 1 | First active pixel of a frame |

## Verification
The embedded properties check the following on every cycle:
- Both scan counters stay inside the current geometry.
- The profile register changes only at a frame wrap.
- The column advances by one through every request run.
- Data-enable never overlaps either sync.
- The frame-start pulse falls on an enabled pixel.

Only the bench scenarios can show that the measured periods, porch offsets and active widths match each profile. The same applies to the colour pairing with the coordinates, to the deferral of a mid-frame profile change, and to the fixed-profile variant ignoring its select pin.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int H_W   = 11;
  localparam int V_W   = 10;
  localparam int RGB_W = 24;

  typedef struct packed {
    logic [H_W-1:0] hact;
    logic [H_W-1:0] hbp;
    logic [H_W-1:0] hfp;
    logic [V_W-1:0] vact;
    logic [V_W-1:0] vbp;
    logic [V_W-1:0] vfp;
  } geom_t;

  typedef enum logic [1:0] {
    PROF_WIDE   = 2'd0,
    PROF_MID    = 2'd1,
    PROF_SMALL  = 2'd2,
    PROF_CUSTOM = 2'd3
  } prof_e;

  function automatic geom_t pick_geom(input logic [1:0] sel, input geom_t cust);
    geom_t g;
    case (prof_e'(sel))
      PROF_WIDE: begin
        g.hact = H_W'(800); g.hbp = H_W'(216); g.hfp = H_W'(40);
        g.vact = V_W'(480); g.vbp = V_W'(35);  g.vfp = V_W'(10);
      end
      PROF_MID: begin
        g.hact = H_W'(480); g.hbp = H_W'(43);  g.hfp = H_W'(2);
        g.vact = V_W'(272); g.vbp = V_W'(12);  g.vfp = V_W'(2);
      end
      PROF_SMALL: begin
        g.hact = H_W'(400); g.hbp = H_W'(108); g.hfp = H_W'(20);
        g.vact = V_W'(240); g.vbp = V_W'(20);  g.vfp = V_W'(2);
      end
      default: g = cust;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/lcdt_scan_ctr.sv
module lcdt_scan_ctr #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] total,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = step && (cnt == total - W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (step) cnt <= cnt + W'(1);
  end

  // R2 / R4: the position never leaves the current geometry
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < total);
endmodule

// File: rtl/lcdt_prof_sel.sv
module lcdt_prof_sel
  import lcdt_pkg::*;
#(
  parameter bit         USE_SEL_PIN = 1'b1,
  parameter logic [1:0] PROFILE     = 2'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_wrap,
  input  logic [1:0] sel,
  input  geom_t      cust,
  output geom_t      geom
);
  logic [1:0] eff_sel;

  generate
    if (USE_SEL_PIN) begin : g_pin
      assign eff_sel = sel;
    end else begin : g_fixed
      assign eff_sel = PROFILE;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || frame_wrap) geom <= pick_geom(eff_sel, cust);
  end

  // R8: the active geometry moves only at a frame boundary
  p_prof_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(geom));
endmodule

// File: rtl/lcdt_out_stage.sv
module lcdt_out_stage
  import lcdt_pkg::*;
#(
  parameter int HSW = 1,
  parameter int VSW = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [H_W-1:0]   hcnt,
  input  logic [V_W-1:0]   vcnt,
  input  logic [H_W-1:0]   hbp,
  input  logic [H_W-1:0]   hact,
  input  logic [V_W-1:0]   vbp,
  input  logic [V_W-1:0]   vact,
  input  logic [RGB_W-1:0] pix_rgb,
  output logic             pix_req,
  output logic [H_W-1:0]   pix_x,
  output logic [V_W-1:0]   pix_y,
  output logic             lcd_hsync_n,
  output logic             lcd_vsync_n,
  output logic             lcd_de,
  output logic [RGB_W-1:0] lcd_rgb,
  output logic             frame_start
);
  logic h_in, v_in;
  logic hs_a, vs_a;

  assign h_in = (hcnt >= hbp) && (hcnt < hbp + hact);
  assign v_in = (vcnt >= vbp) && (vcnt < vbp + vact);

  // request stage: coordinates for the source, one clock ahead of the panel bus
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_req <= 1'b0;
      pix_x   <= '0;
      pix_y   <= '0;
      hs_a    <= 1'b1;
      vs_a    <= 1'b1;
    end else begin
      pix_req <= h_in && v_in;
      pix_x   <= hcnt - hbp;
      pix_y   <= vcnt - vbp;
      hs_a    <= !(hcnt < H_W'(HSW));
      vs_a    <= !(vcnt < V_W'(VSW));
    end
  end

  // panel stage: syncs, enable and colour leave together
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcd_de      <= 1'b0;
      lcd_rgb     <= '0;
      lcd_hsync_n <= 1'b1;
      lcd_vsync_n <= 1'b1;
      frame_start <= 1'b0;
    end else begin
      lcd_de      <= pix_req;
      lcd_rgb     <= pix_req ? pix_rgb : '0;
      lcd_hsync_n <= hs_a;
      lcd_vsync_n <= vs_a;
      frame_start <= pix_req && (pix_x == '0) && (pix_y == '0);
    end
  end

  // R5: the column steps by one through a request run
  p_x_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_req && $past(pix_req)) |-> (pix_x == $past(pix_x) + H_W'(1)));
  // R5: a requested column lies inside the active width
  p_x_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req |-> (pix_x < hact));
  // R3: enable never overlaps a sync pulse
  p_de_no_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_de |-> (lcd_hsync_n && lcd_vsync_n));
  // R7: the frame marker sits on an enabled pixel
  p_fs_on_de_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> lcd_de);
endmodule

// File: rtl/lcdt_panel_timing.sv
module lcdt_panel_timing
  import lcdt_pkg::*;
#(
  parameter bit         USE_SEL_PIN = 1'b1,
  parameter logic [1:0] PROFILE     = 2'd0,
  parameter int         HSW         = 1,
  parameter int         VSW         = 1,
  parameter int         CUST_HACT   = 640,
  parameter int         CUST_HBP    = 48,
  parameter int         CUST_HFP    = 16,
  parameter int         CUST_VACT   = 360,
  parameter int         CUST_VBP    = 20,
  parameter int         CUST_VFP    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       prof_sel,
  output logic             pix_req,
  output logic [H_W-1:0]   pix_x,
  output logic [V_W-1:0]   pix_y,
  input  logic [RGB_W-1:0] pix_rgb,
  output logic             lcd_hsync_n,
  output logic             lcd_vsync_n,
  output logic             lcd_de,
  output logic [RGB_W-1:0] lcd_rgb,
  output logic             frame_start
);
  localparam geom_t CUST_G = '{
    hact: H_W'(CUST_HACT), hbp: H_W'(CUST_HBP), hfp: H_W'(CUST_HFP),
    vact: V_W'(CUST_VACT), vbp: V_W'(CUST_VBP), vfp: V_W'(CUST_VFP)
  };

  geom_t          geom;
  logic [H_W-1:0] h_tot, hcnt;
  logic [V_W-1:0] v_tot, vcnt;
  logic           h_wrap, v_wrap;

  assign h_tot = geom.hact + geom.hbp + geom.hfp;
  assign v_tot = geom.vact + geom.vbp + geom.vfp;

  lcdt_prof_sel #(.USE_SEL_PIN(USE_SEL_PIN), .PROFILE(PROFILE)) u_prof (
    .clk(clk), .rst_n(rst_n), .frame_wrap(v_wrap), .sel(prof_sel),
    .cust(CUST_G), .geom(geom)
  );

  lcdt_scan_ctr #(.W(H_W)) u_hctr (
    .clk(clk), .rst_n(rst_n), .step(1'b1), .total(h_tot),
    .cnt(hcnt), .wrap(h_wrap)
  );

  lcdt_scan_ctr #(.W(V_W)) u_vctr (
    .clk(clk), .rst_n(rst_n), .step(h_wrap), .total(v_tot),
    .cnt(vcnt), .wrap(v_wrap)
  );

  lcdt_out_stage #(.HSW(HSW), .VSW(VSW)) u_out (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
    .hbp(geom.hbp), .hact(geom.hact), .vbp(geom.vbp), .vact(geom.vact),
    .pix_rgb(pix_rgb), .pix_req(pix_req), .pix_x(pix_x), .pix_y(pix_y),
    .lcd_hsync_n(lcd_hsync_n), .lcd_vsync_n(lcd_vsync_n), .lcd_de(lcd_de),
    .lcd_rgb(lcd_rgb), .frame_start(frame_start)
  );

  // R4: the line counter moves only when a line ends
  p_v_on_line_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !h_wrap |=> $stable(vcnt));
endmodule

// File: tb/tb_lcdt_panel_timing.sv
module tb_lcdt_panel_timing;
  localparam int CLK_P = 10;
  localparam int HSW = 2, VSW = 2;
  localparam int CHA = 6, CHB = 4, CHF = 3, CVA = 3, CVB = 3, CVF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  prof_sel = 2'd3;
  logic        pix_req, lcd_hsync_n, lcd_vsync_n, lcd_de, frame_start;
  logic [10:0] pix_x;
  logic [9:0]  pix_y;
  logic [23:0] pix_rgb, lcd_rgb;
  logic        f_req, f_hs, f_vs, f_de, f_fs;
  logic [10:0] f_x;
  logic [9:0]  f_y;
  logic [23:0] f_rgb;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [23:0] pix_of(int x, int y);
    return {8'(x) ^ 8'h3C, 8'(y), 8'(x >> 3) + 8'(y)};
  endfunction

  assign pix_rgb = pix_of(int'(pix_x), int'(pix_y));

  lcdt_panel_timing #(.HSW(HSW), .VSW(VSW), .CUST_HACT(CHA), .CUST_HBP(CHB),
    .CUST_HFP(CHF), .CUST_VACT(CVA), .CUST_VBP(CVB), .CUST_VFP(CVF)) dut (
    .clk(clk), .rst_n(rst_n), .prof_sel(prof_sel), .pix_req(pix_req),
    .pix_x(pix_x), .pix_y(pix_y), .pix_rgb(pix_rgb), .lcd_hsync_n(lcd_hsync_n),
    .lcd_vsync_n(lcd_vsync_n), .lcd_de(lcd_de), .lcd_rgb(lcd_rgb),
    .frame_start(frame_start));

  // fixed-profile variant: select pin tied to another code
  lcdt_panel_timing #(.USE_SEL_PIN(1'b0), .PROFILE(2'd3), .HSW(HSW), .VSW(VSW),
    .CUST_HACT(CHA), .CUST_HBP(CHB), .CUST_HFP(CHF), .CUST_VACT(CVA),
    .CUST_VBP(CVB), .CUST_VFP(CVF)) dut_fix (
    .clk(clk), .rst_n(rst_n), .prof_sel(2'd1), .pix_req(f_req), .pix_x(f_x),
    .pix_y(f_y), .pix_rgb(24'd0), .lcd_hsync_n(f_hs), .lcd_vsync_n(f_vs),
    .lcd_de(f_de), .lcd_rgb(f_rgb), .frame_start(f_fs));

  // geometry tables, indexed by profile code
  function automatic int t_ha(int p); case (p) 0: return 800; 1: return 480; 2: return 400; default: return CHA; endcase endfunction
  function automatic int t_hb(int p); case (p) 0: return 216; 1: return 43;  2: return 108; default: return CHB; endcase endfunction
  function automatic int t_hf(int p); case (p) 0: return 40;  1: return 2;   2: return 20;  default: return CHF; endcase endfunction
  function automatic int t_va(int p); case (p) 0: return 480; 1: return 272; 2: return 240; default: return CVA; endcase endfunction
  function automatic int t_vb(int p); case (p) 0: return 35;  1: return 12;  2: return 20;  default: return CVB; endcase endfunction
  function automatic int t_vf(int p); case (p) 0: return 10;  1: return 2;   2: return 2;   default: return CVF; endcase endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // behavioural reference: scan position, then a two-deep delay line
  int mh, mv, mp;
  bit a_req, a_hs, a_vs, b_de, b_hs, b_vs, b_fs;
  int a_x, a_y;
  logic [23:0] b_rgb;

  always @(posedge clk) begin
    if (!rst_n) begin
      mh <= 0; mv <= 0; mp <= int'(prof_sel);
      a_req <= 0; a_x <= 0; a_y <= 0; a_hs <= 1; a_vs <= 1;
      b_de <= 0; b_rgb <= '0; b_hs <= 1; b_vs <= 1; b_fs <= 0;
    end else begin
      b_de  <= a_req;
      b_rgb <= a_req ? pix_of(a_x, a_y) : 24'd0;
      b_hs  <= a_hs;
      b_vs  <= a_vs;
      b_fs  <= a_req && a_x == 0 && a_y == 0;
      a_req <= (mh >= t_hb(mp)) && (mh < t_hb(mp) + t_ha(mp)) &&
               (mv >= t_vb(mp)) && (mv < t_vb(mp) + t_va(mp));
      a_x   <= mh - t_hb(mp);
      a_y   <= mv - t_vb(mp);
      a_hs  <= !(mh < HSW);
      a_vs  <= !(mv < VSW);
      if (mh == t_ha(mp) + t_hb(mp) + t_hf(mp) - 1) begin
        mh <= 0;
        if (mv == t_va(mp) + t_vb(mp) + t_vf(mp) - 1) begin
          mv <= 0; mp <= int'(prof_sel);
        end else mv <= mv + 1;
      end else mh <= mh + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(lcd_hsync_n == b_hs, "R2 hsync", lcd_hsync_n, b_hs);
      chk(lcd_vsync_n == b_vs, "R4 vsync", lcd_vsync_n, b_vs);
      chk(lcd_de == b_de, "R3 de", lcd_de, b_de);
      chk(pix_req == a_req, "R5 req", pix_req, a_req);
      if (a_req) chk(int'(pix_x) == a_x && int'(pix_y) == a_y, "R5 xy",
                     {pix_y, pix_x}, {10'(a_y), 11'(a_x)});
      chk(lcd_rgb == b_rgb, "R6 rgb", lcd_rgb, b_rgb);
      chk(frame_start == b_fs, "R7 frame_start", frame_start, b_fs);
    end
  end

  function automatic logic sig(int id);
    case (id)
      0: return lcd_hsync_n;
      1: return lcd_vsync_n;
      2: return lcd_de;
      default: return f_hs;
    endcase
  endfunction

  task automatic wait_edge(input int id, input bit rise);
    logic p;
    bit hit;
    p = sig(id);
    do begin
      @(negedge clk);
      hit = rise ? (!p && sig(id)) : (p && !sig(id));
      p = sig(id);
    end while (!hit);
  endtask

  task automatic count_to_edge(input int id, input bit rise, output int n);
    logic p;
    bit hit;
    p = sig(id);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      hit = rise ? (!p && sig(id)) : (p && !sig(id));
      p = sig(id);
    end while (!hit);
  endtask

  task automatic line_period(input int id, input int exp, input string req);
    int n;
    wait_edge(id, 0);
    count_to_edge(id, 0, n);
    chk(n == exp, req, n, exp);
  endtask

  task automatic de_shape(input int hb, input int ha, input string req);
    int n;
    wait_edge(2, 1);
    count_to_edge(2, 0, n);
    chk(n == ha, {req, " de width"}, n, ha);
    wait_edge(0, 0);
    count_to_edge(2, 1, n);
    chk(n == hb, {req, " de offset after hsync"}, n, hb);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !done) begin
      chk(1'b0, "watchdog", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int n, fs_cnt;
    // R1: reset values
    repeat (3) @(negedge clk);
    chk(lcd_hsync_n && lcd_vsync_n, "R1 syncs idle high", {lcd_hsync_n, lcd_vsync_n}, 3);
    chk(!lcd_de && !pix_req && !frame_start, "R1 enables low",
        {lcd_de, pix_req, frame_start}, 0);
    chk(lcd_rgb == 0, "R1 rgb zero", lcd_rgb, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lcd_hsync_n && !lcd_de, "R1 first cycle after reset", {lcd_hsync_n, lcd_de}, 2);

    // custom profile (code 3)
    line_period(0, CHA + CHB + CHF, "R2 custom line period");
    wait_edge(0, 0);
    chk(lcd_hsync_n == 0, "R2 hsync low", lcd_hsync_n, 0);
    count_to_edge(0, 1, n);
    chk(n == HSW, "R2 hsync width", n, HSW);
    de_shape(CHB, CHA, "R3 custom");
    wait_edge(1, 0);
    count_to_edge(1, 1, n);
    chk(n == VSW * (CHA + CHB + CHF), "R4 vsync width", n, VSW * 13);
    wait_edge(1, 0);
    count_to_edge(1, 0, n);
    chk(n == 8 * 13, "R4 custom frame period", n, 104);
    fs_cnt = 0;
    repeat (3 * 104) begin
      @(negedge clk);
      if (frame_start) fs_cnt++;
    end
    chk(fs_cnt == 3, "R7 one frame_start per frame", fs_cnt, 3);
    line_period(3, 13, "R9 fixed variant ignores its pin");

    // R8: mid-frame switch to code 2, no effect until the frame ends
    wait_edge(1, 0);
    repeat (30) @(negedge clk);
    prof_sel = 2'd2;
    line_period(0, 13, "R8 old timing kept mid-frame");
    wait_edge(1, 0);
    count_to_edge(1, 1, n);
    chk(n == VSW * 528, "R8 R4 new profile vsync width", n, VSW * 528);
    line_period(0, 528, "R2 R8 profile 2 line period");
    prof_sel = 2'd3;
    line_period(0, 528, "R8 change ignored mid-frame");
    de_shape(108, 400, "R3 profile 2");
    line_period(3, 13, "R9 fixed variant still custom");

    // profile 1 from reset
    @(negedge clk); rst_n = 1'b0; prof_sel = 2'd1;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    line_period(0, 525, "R2 profile 1 line period");
    de_shape(43, 480, "R3 profile 1");

    // profile 0 from reset
    @(negedge clk); rst_n = 1'b0; prof_sel = 2'd0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    line_period(0, 1056, "R2 profile 0 line period");
    de_shape(216, 800, "R3 profile 0");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule